// File: doc/BRIEF.md
# CLOCK Replacement Victim Selector

This block picks a frame to evict from a fixed ring of physical frames. It uses the clock policy, which approximates least-recently-used with one reference bit per frame. Each access marks a frame as recently used by setting its reference bit. A rotating hand remembers where the last search ended.

When the host asks for a victim, the block walks the ring from the hand and examines one frame per clock cycle. A frame whose bit is set is given a second chance: its bit is cleared and the walk moves on. The first frame found with a clear bit is returned as the victim, and the hand moves to the frame after it.

Accesses keep arriving while a walk is running, and they take effect at once.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset all reference bits are clear, the hand points to frame 0, `busy_o` and `victim_valid_o` are low, and the first victim request returns frame 0.
- R2: A request (`victim_req_i` high at a clock edge while `busy_o` is low) raises `busy_o` from the next cycle. `busy_o` stays high until the victim is reported and is low in the cycle `victim_valid_o` is high.
- R3: A victim is reported by `victim_valid_o` high for exactly one cycle, with `victim_idx_o` holding the frame index. The walk examines one frame per cycle, so a victim that lies k frames past the hand is reported k+1 cycles after the request edge.
- R4: The walk clears the reference bit of every frame it passes whose bit is set. The victim is the first frame, going in increasing index order from the hand, whose bit was clear when examined.
- R5: After a victim is chosen, the hand points to victim index + 1, and the next walk starts there.
- R6: If every bit is set, the walk clears all of them and returns the starting frame. The victim is reported N+1 cycles after the request edge, where N is the frame count.
- R7: An access (`acc_valid_i` high at an edge) sets the bit of frame `acc_idx_i`. If the walk clears that same frame at the same edge, the access wins and the bit stays set.
- R8: `victim_req_i` is ignored while `busy_o` is high. It starts no second walk and produces no extra victim.
- R9: `NUM_FRAMES` must be a power of two, at least 2. The hand and the walk wrap from frame N-1 to frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| acc_valid_i | input | 1 | Frame access strobe |
| acc_idx_i | input | $clog2(NUM_FRAMES) | Index of the accessed frame |
| victim_req_i | input | 1 | Request a victim search |
| busy_o | output | 1 | A search is in progress |
| victim_valid_o | output | 1 | One-cycle victim report |
| victim_idx_o | output | $clog2(NUM_FRAMES) | Chosen victim frame |

## Verification
The checker watches these properties on every cycle:
- the victim report is a single-cycle pulse;
- `busy_o` drops only together with a report;
- a request while idle always starts a walk, and a walk never ends without a report;
- an access always leaves its bit set one cycle later;
- a reported victim had a clear bit when it was examined.

Which frame is chosen, where the hand ends up, the N+1-cycle latency of the all-set case, the wrap past the last frame, and the effect of an access that collides with a clear are shown only by the bench. It checks these against a cycle model built from the requirements, under directed scenarios and random accesses mixed with random requests.

// File: rtl/clock_victim_pkg.sv
package clock_victim_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SCAN = 1'b1
    } phase_e;
endpackage

// File: rtl/clock_ref_bits.sv
module clock_ref_bits #(
    parameter int NUM_FRAMES = 16,
    localparam int IDX_W = $clog2(NUM_FRAMES)
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  acc_valid_i,
    input  logic [IDX_W-1:0]      acc_idx_i,
    input  logic                  clr_en_i,
    input  logic [IDX_W-1:0]      clr_idx_i,
    output logic [NUM_FRAMES-1:0] ref_o
);
    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
        logic hit_set;
        logic hit_clr;
        logic bit_d;
        logic bit_q;

        assign hit_set = acc_valid_i && (acc_idx_i == IDX_W'(g));
        assign hit_clr = clr_en_i && (clr_idx_i == IDX_W'(g));

        // a set from an access outranks a clear from the walk
        always_comb begin
            bit_d = bit_q;
            if (hit_clr) bit_d = 1'b0;
            if (hit_set) bit_d = 1'b1;
        end

        always_ff @(posedge clk_i) begin
            if (!rst_ni) bit_q <= 1'b0;
            else         bit_q <= bit_d;
        end

        assign ref_o[g] = bit_q;
    end
endmodule

// File: rtl/clock_sweep_ctrl.sv
module clock_sweep_ctrl
    import clock_victim_pkg::*;
#(
    parameter int NUM_FRAMES = 16,
    localparam int IDX_W = $clog2(NUM_FRAMES)
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  req_i,
    input  logic [NUM_FRAMES-1:0] ref_i,
    output logic                  clr_en_o,
    output logic [IDX_W-1:0]      clr_idx_o,
    output logic                  busy_o,
    output logic                  victim_valid_o,
    output logic [IDX_W-1:0]      victim_idx_o
);
    typedef struct packed {
        phase_e           phase;
        logic [IDX_W-1:0] ptr;
        logic [IDX_W-1:0] hand;
        logic             vvalid;
        logic [IDX_W-1:0] vidx;
    } ctrl_t;

    ctrl_t st_d;
    ctrl_t st_q;

    always_comb begin
        st_d        = st_q;
        st_d.vvalid = 1'b0;
        clr_en_o    = 1'b0;
        clr_idx_o   = st_q.ptr;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_i) begin
                    st_d.phase = PH_SCAN;
                    st_d.ptr   = st_q.hand;
                end
            end
            PH_SCAN: begin
                if (ref_i[st_q.ptr]) begin
                    // second chance: drop the mark and move on
                    clr_en_o = 1'b1;
                    st_d.ptr = st_q.ptr + IDX_W'(1);
                end else begin
                    st_d.vvalid = 1'b1;
                    st_d.vidx   = st_q.ptr;
                    st_d.hand   = st_q.ptr + IDX_W'(1);
                    st_d.phase  = PH_IDLE;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.phase  <= PH_IDLE;
            st_q.ptr    <= '0;
            st_q.hand   <= '0;
            st_q.vvalid <= 1'b0;
            st_q.vidx   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o         = (st_q.phase == PH_SCAN);
    assign victim_valid_o = st_q.vvalid;
    assign victim_idx_o   = st_q.vidx;
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
    parameter int NUM_FRAMES = 16,
    localparam int IDX_W = $clog2(NUM_FRAMES)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             acc_valid_i,
    input  logic [IDX_W-1:0] acc_idx_i,
    input  logic             victim_req_i,
    output logic             busy_o,
    output logic             victim_valid_o,
    output logic [IDX_W-1:0] victim_idx_o
);
    logic [NUM_FRAMES-1:0] ref_w;
    logic                  clr_en_w;
    logic [IDX_W-1:0]      clr_idx_w;

    clock_ref_bits #(.NUM_FRAMES(NUM_FRAMES)) u_bits (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .acc_valid_i (acc_valid_i),
        .acc_idx_i   (acc_idx_i),
        .clr_en_i    (clr_en_w),
        .clr_idx_i   (clr_idx_w),
        .ref_o       (ref_w)
    );

    clock_sweep_ctrl #(.NUM_FRAMES(NUM_FRAMES)) u_ctrl (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .req_i          (victim_req_i),
        .ref_i          (ref_w),
        .clr_en_o       (clr_en_w),
        .clr_idx_o      (clr_idx_w),
        .busy_o         (busy_o),
        .victim_valid_o (victim_valid_o),
        .victim_idx_o   (victim_idx_o)
    );
endmodule

// File: rtl/clock_victim_sel_chk.sv
module clock_victim_sel_chk #(
    parameter int NUM_FRAMES = 16,
    localparam int IDX_W = $clog2(NUM_FRAMES)
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  acc_valid_i,
    input logic [IDX_W-1:0]      acc_idx_i,
    input logic                  victim_req_i,
    input logic                  busy_o,
    input logic                  victim_valid_o,
    input logic [IDX_W-1:0]      victim_idx_o,
    input logic [NUM_FRAMES-1:0] ref_bits
);
    logic [NUM_FRAMES-1:0] ref_prev;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) ref_prev <= '0;
        else         ref_prev <= ref_bits;
    end

    a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        victim_valid_o |=> !victim_valid_o);

    a_r2_busy_ends_with_victim: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> victim_valid_o);

    a_r2_idle_req_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && victim_req_i) |=> busy_o);

    a_r8_walk_runs_to_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> (busy_o || victim_valid_o));

    a_r7_access_sets_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_valid_i |=> ref_bits[$past(acc_idx_i)]);

    a_r4_victim_was_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        victim_valid_o |-> !ref_prev[victim_idx_o]);
endmodule

bind clock_victim_sel clock_victim_sel_chk #(.NUM_FRAMES(NUM_FRAMES)) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .acc_valid_i    (acc_valid_i),
    .acc_idx_i      (acc_idx_i),
    .victim_req_i   (victim_req_i),
    .busy_o         (busy_o),
    .victim_valid_o (victim_valid_o),
    .victim_idx_o   (victim_idx_o),
    .ref_bits       (ref_w)
);

// File: tb/clock_victim_sel_tb_top.sv
`timescale 1ns/1ps
module clock_victim_sel_tb_top;
    localparam int N     = 16;
    localparam int IDX_W = $clog2(N);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acc_valid = 1'b0;
    logic [IDX_W-1:0] acc_idx = '0;
    logic             victim_req = 1'b0;
    logic             busy;
    logic             victim_valid;
    logic [IDX_W-1:0] victim_idx;

    always #2 clk = ~clk;

    clock_victim_sel #(.NUM_FRAMES(N)) dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .acc_valid_i    (acc_valid),
        .acc_idx_i      (acc_idx),
        .victim_req_i   (victim_req),
        .busy_o         (busy),
        .victim_valid_o (victim_valid),
        .victim_idx_o   (victim_idx)
    );

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 0;

    // reference model
    bit  m_ref [N];
    int  m_hand, m_ptr, m_vi;
    bit  m_busy, m_vv;

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic void model_edge(input bit av, input int ai, input bit rq);
        m_vv = 0;
        if (!m_busy) begin
            if (rq) begin m_busy = 1; m_ptr = m_hand; end
        end else if (m_ref[m_ptr]) begin
            m_ref[m_ptr] = 0;
            m_ptr = (m_ptr + 1) % N;
        end else begin
            m_vv = 1; m_vi = m_ptr;
            m_hand = (m_ptr + 1) % N;
            m_busy = 0;
        end
        if (av) m_ref[ai] = 1;
    endfunction

    task automatic step(input bit av, input int ai, input bit rq, input string tag);
        acc_valid  = av;
        acc_idx    = IDX_W'(ai);
        victim_req = rq;
        @(posedge clk);
        model_edge(av, ai, rq);
        @(negedge clk);
        check(tag, "busy", int'(busy), int'(m_busy));
        check(tag, "valid", int'(victim_valid), int'(m_vv));
        if (m_vv) check(tag, "victim_idx", int'(victim_idx), m_vi);
    endtask

    // request and run until the model reports; returns the cycle count
    task automatic sweep(input string tag, output int cycles);
        step(0, 0, 1, tag);
        cycles = 0;
        for (int k = 0; k < N + 4; k++) begin
            step(0, 0, 0, tag);
            cycles++;
            if (m_vv) break;
        end
    endtask

    initial begin : watchdog
        #(4 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        int cyc;
        int h0;
        void'($urandom(32'h5eed_c10c));
        for (int i = 0; i < N; i++) m_ref[i] = 0;
        m_hand = 0; m_ptr = 0; m_busy = 0; m_vv = 0; m_vi = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and first victim
        check("R1", "busy", int'(busy), 0);
        check("R1", "valid", int'(victim_valid), 0);
        sweep("R1", cyc);
        check("R1", "victim", int'(victim_idx), 0);
        check("R3", "latency", cyc, 1);

        // R5: hand moved past frame 0
        sweep("R5", cyc);
        check("R5", "victim", int'(victim_idx), 1);

        // R4: frames 2 and 3 marked get passed over
        step(1, 2, 0, "R4");
        step(1, 3, 0, "R4");
        sweep("R4", cyc);
        check("R4", "victim", int'(victim_idx), 4);
        check("R3", "latency", cyc, 3);

        // R6: all marked
        for (int i = 0; i < N; i++) step(1, i, 0, "R6");
        h0 = m_hand;
        sweep("R6", cyc);
        check("R6", "victim", int'(victim_idx), h0);
        check("R6", "latency", cyc, N + 1);
        sweep("R6", cyc);
        check("R6", "next victim", int'(victim_idx), (h0 + 1) % N);
        check("R6", "next latency", cyc, 1);

        // R8: request held high through a walk
        step(1, m_hand, 0, "R8");
        step(1, (m_hand + 1) % N, 0, "R8");
        step(0, 0, 1, "R8");
        for (int k = 0; k < 3; k++) step(0, 0, 1, "R8");
        check("R8", "victim seen", int'(victim_valid), 1);
        step(0, 0, 0, "R8");
        for (int k = 0; k < 3; k++) step(0, 0, 0, "R8");

        // R7: access collides with clear of the starting frame
        for (int i = 0; i < N; i++) step(1, i, 0, "R7");
        h0 = m_hand;
        step(0, 0, 1, "R7");
        step(1, h0, 0, "R7");
        cyc = 1;
        for (int k = 0; k < N + 4; k++) begin
            if (m_vv) break;
            step(0, 0, 0, "R7");
            cyc++;
        end
        check("R7", "victim", int'(victim_idx), (h0 + 1) % N);
        check("R7", "latency", cyc, N + 2);

        // R9: wrap from the last frame
        for (int k = 0; k < 2 * N && m_hand != N - 1; k++) sweep("R9", cyc);
        check("R9", "hand at last", m_hand, N - 1);
        step(1, N - 1, 0, "R9");
        sweep("R9", cyc);
        check("R9", "wrapped victim", int'(victim_idx), 0);

        // random traffic, all behaviours (R3 timing on every step)
        for (int t = 0; t < 4000; t++) begin
            bit av = ($urandom % 3) == 0;
            int ai = int'($urandom % N);
            bit rq = ($urandom % 6) == 0;
            step(av, ai, rq, "R3");
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule